// File: doc/BRIEF.md
# Threshold-Population Integer Divider

This block forms an approximate integer quotient of two streams of per-step spike counts. It uses only adders, right shifts and magnitude comparators. A transaction has two phases, and each phase lasts T input steps. In the first phase the divisor stream is summed. The sum, shifted right by n = log2(T·L) bits, becomes a base threshold θ. A chain of adders turns θ into a ladder of graded thresholds θ, 2θ, …, Pθ, one for each of P = T·L comparator units.

In the second phase each dividend step is presented to every unit at the same time. Each unit whose threshold the step reaches counts as having fired. The number of fired units is summed over all T steps. That total, shifted right by n, is the quotient. A divisor sum too small to yield a nonzero θ raises a divide-by-zero flag and saturates the quotient.

The controller is a four-state machine:
- `ST_IDLE` waits for `start`.
- `ST_DEN` collects divisor steps. It moves to `ST_NUM` on the T-th accepted divisor step.
- `ST_NUM` collects dividend steps. It moves to `ST_DONE` on the T-th accepted dividend step.
- `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

A `start` pulse moves the machine from any state to `ST_DEN`.

Top module: `threshold_divider`

## Requirements
- R1: After reset, `done` and `div_zero` are 0 and `quotient` is 0.
- R2: In `ST_DEN`, each cycle with `in_valid`=1 and `in_phase`=0 adds `in_data` to the divisor sum. After T such steps the block moves to the dividend phase.
- R3: The base threshold θ is the divisor sum shifted right by n = log2(T·L) bits. It stays fixed for the whole dividend phase.
- R4: Unit i (i = 1…P, P = T·L) fires for a dividend step exactly when `in_data` ≥ i·θ. The units that fire therefore always form a contiguous run starting at unit 1.
- R5: The firing counts of the T dividend steps (`in_phase`=1) are summed. `quotient` is that sum shifted right by n. With the default parameters (T=4, L=4, n=4), `quotient` is 3 bits wide and never exceeds T unless it saturates.
- R6: `done` is high for exactly one cycle. That cycle directly follows the clock edge that accepted the last dividend step. `quotient` and `div_zero` change only at that edge and hold until the next completion.
- R7: If θ = 0 (divisor sum below 2^n), `div_zero` is 1 and `quotient` is all ones (7 with the defaults).
- R8: The following inputs are ignored: inputs with `in_valid`=0, inputs whose `in_phase` does not match the current phase, and any input while idle.
- R9: `start` moves the block from any state to the divisor phase and clears both sums and the step count. An input presented in the same cycle as `start` is ignored.
- R10: A dividend step at or above P·θ fires all P units, so one step contributes at most P to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new transaction |
| in_valid | input | 1 | Qualifies `in_data` |
| in_phase | input | 1 | 0 = divisor step, 1 = dividend step |
| in_data | input | DATA_W | Per-step spike count |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | STEPS_LOG2+1 | Quotient, held between completions |
| div_zero | output | 1 | Base threshold was zero; held with `quotient` |

## Verification
The hardest situation to reach is a restart that arrives together with a valid divisor step while a divisor phase is half finished. If the same-cycle step were wrongly accepted, it would shift every following step by one slot.

The stimulus covers this by feeding two divisor steps, then raising `start` with a large divisor value beside it, then running a full transaction. The chosen values make a leaked step drive the quotient from 2 to 0.

Saturation is reached in two ways. One vector's dividend steps exceed P·θ. Another vector has a nonzero divisor sum that still gives a zero θ.

// File: rtl/td_pkg.sv
package td_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DEN  = 2'd1,
        ST_NUM  = 2'd2,
        ST_DONE = 2'd3
    } td_state_e;

endpackage

// File: rtl/td_threshold_ladder.sv
module td_threshold_ladder #(
    parameter int THETA_W = 6,
    parameter int SUM_W   = 10,
    parameter int UNITS   = 16
) (
    input  logic [THETA_W-1:0] theta,
    output logic [SUM_W-1:0]   rung [UNITS]
);

    // rung[g] holds (g+1)*theta, built by chained addition
    assign rung[0] = SUM_W'(theta);

    for (genvar g = 1; g < UNITS; g++) begin : g_rung
        assign rung[g] = rung[g-1] + SUM_W'(theta);
    end

endmodule

// File: rtl/td_unit_bank.sv
module td_unit_bank #(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 10,
    parameter int UNITS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample,
    input  logic [SUM_W-1:0]  rung [UNITS],
    output logic [UNITS-1:0]  fire
);

    for (genvar g = 0; g < UNITS; g++) begin : g_unit
        assign fire[g] = SUM_W'(sample) >= rung[g];
    end

    // R4
    thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire & (fire + UNITS'(1))) == '0);

endmodule

// File: rtl/td_fire_counter.sv
module td_fire_counter #(
    parameter int UNITS = 16,
    parameter int CNT_W = 5
) (
    input  logic [UNITS-1:0] fire,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int k = 0; k < UNITS; k++) begin
            count = count + CNT_W'(fire[k]);
        end
    end

endmodule

// File: rtl/threshold_divider.sv
module threshold_divider #(
    parameter int DATA_W      = 8,
    parameter int STEPS_LOG2  = 2,
    parameter int LEVELS_LOG2 = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  in_valid,
    input  logic                  in_phase,
    input  logic [DATA_W-1:0]     in_data,
    output logic                  done,
    output logic [STEPS_LOG2:0]   quotient,
    output logic                  div_zero
);
    import td_pkg::*;

    localparam int STEPS   = 1 << STEPS_LOG2;
    localparam int SHIFT   = STEPS_LOG2 + LEVELS_LOG2;
    localparam int UNITS   = 1 << SHIFT;
    localparam int SUM_W   = DATA_W + STEPS_LOG2;
    localparam int THETA_W = SUM_W - SHIFT;
    localparam int POP_W   = SHIFT + 1;
    localparam int ACC_W   = STEPS_LOG2 + SHIFT + 1;
    localparam int Q_W     = STEPS_LOG2 + 1;
    localparam int STEP_W  = STEPS_LOG2;

    td_state_e           state, state_nx;
    logic [STEP_W-1:0]   step_cnt;
    logic [SUM_W-1:0]    den_sum;
    logic [ACC_W-1:0]    fire_acc;
    logic [ACC_W-1:0]    acc_next;
    logic [THETA_W-1:0]  theta;
    logic [SUM_W-1:0]    rung [UNITS];
    logic [UNITS-1:0]    fire;
    logic [POP_W-1:0]    pop;
    logic                last_step;
    logic                den_take;
    logic                num_take;
    logic                theta_zero;

    assign theta      = den_sum[SUM_W-1:SHIFT];
    assign theta_zero = (theta == '0);
    assign last_step  = (step_cnt == STEP_W'(STEPS - 1));
    assign den_take   = (state == ST_DEN) && in_valid && !in_phase && !start;
    assign num_take   = (state == ST_NUM) && in_valid &&  in_phase && !start;
    assign acc_next   = fire_acc + ACC_W'(pop);

    td_threshold_ladder #(
        .THETA_W (THETA_W),
        .SUM_W   (SUM_W),
        .UNITS   (UNITS)
    ) u_ladder (
        .theta (theta),
        .rung  (rung)
    );

    td_unit_bank #(
        .DATA_W (DATA_W),
        .SUM_W  (SUM_W),
        .UNITS  (UNITS)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (in_data),
        .rung   (rung),
        .fire   (fire)
    );

    td_fire_counter #(
        .UNITS (UNITS),
        .CNT_W (POP_W)
    ) u_count (
        .fire  (fire),
        .count (pop)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = ST_DEN;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_DEN:  if (den_take && last_step) state_nx = ST_NUM;
                ST_NUM:  if (num_take && last_step) state_nx = ST_DONE;
                ST_DONE: state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt <= '0;
            den_sum  <= '0;
            fire_acc <= '0;
            quotient <= '0;
            div_zero <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= num_take && last_step;
            if (start) begin
                step_cnt <= '0;
                den_sum  <= '0;
                fire_acc <= '0;
            end else if (den_take) begin
                den_sum  <= den_sum + SUM_W'(in_data);
                step_cnt <= step_cnt + STEP_W'(1);
            end else if (num_take) begin
                fire_acc <= acc_next;
                step_cnt <= step_cnt + STEP_W'(1);
                if (last_step) begin
                    div_zero <= theta_zero;
                    quotient <= theta_zero ? '1 : acc_next[ACC_W-1:SHIFT];
                end
            end
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state == ST_DONE);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(div_zero)));

    // R7
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quotient == '1));

    // R5
    q_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (quotient <= Q_W'(STEPS)));

    // R3
    theta_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NUM && !start) |=> $stable(den_sum));

endmodule

// File: tb/threshold_divider_test.sv
module threshold_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {den0,den1,den2,den3,num0,num1,num2,num3, exp_q[3:0], exp_dz[3:0]}
    localparam logic [71:0] VEC [NVEC] = '{
        {8'd16, 8'd16, 8'd16, 8'd16,  8'd40, 8'd40, 8'd40, 8'd40,   4'd2, 4'd0},
        {8'd255,8'd255,8'd255,8'd255, 8'd255,8'd255,8'd255,8'd255,  4'd1, 4'd0},
        {8'd1,  8'd2,  8'd3,  8'd4,   8'd90, 8'd90, 8'd90, 8'd90,   4'd7, 4'd1},
        {8'd4,  8'd4,  8'd4,  8'd4,   8'd255,8'd255,8'd255,8'd255,  4'd4, 4'd0},
        {8'd100,8'd0,  8'd0,  8'd0,   8'd30, 8'd0,  8'd60, 8'd12,   4'd1, 4'd0},
        {8'd32, 8'd32, 8'd32, 8'd32,  8'd7,  8'd7,  8'd7,  8'd7,    4'd0, 4'd0},
        {8'd8,  8'd0,  8'd0,  8'd8,   8'd3,  8'd5,  8'd0,  8'd9,    4'd1, 4'd0},
        {8'd50, 8'd50, 8'd50, 8'd50,  8'd200,8'd100,8'd150,8'd24,   4'd2, 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_phase = 1'b0;
    logic [7:0] in_data = '0;
    logic       done;
    logic [2:0] quotient;
    logic       div_zero;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    threshold_divider uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .in_phase (in_phase),
        .in_data  (in_data),
        .done     (done),
        .quotient (quotient),
        .div_zero (div_zero)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic feed(input logic ph, input logic [7:0] v);
        in_valid = 1'b1;
        in_phase = ph;
        in_data  = v;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // feeds both phases after start; ends on the negedge after the last dividend edge
    task automatic run_phases(input logic [63:0] s);
        for (int t = 0; t < 4; t++) feed(1'b0, s[63 - 8*t -: 8]);
        for (int t = 0; t < 4; t++) begin
            check(done == 1'b0, "R6 no early done", done, 0);
            feed(1'b1, s[31 - 8*t -: 8]);
        end
    endtask

    task automatic check_result(input int eq, input int edz, input string tag);
        check(done == 1'b1, {tag, " R6 done pulse"}, done, 1);
        check(quotient == eq[2:0], {tag, " R5 quotient"}, quotient, eq);
        check(div_zero == edz[0], {tag, " R7 div_zero"}, div_zero, edz);
        @(negedge clk);
        check(done == 1'b0, {tag, " R6 done one cycle"}, done, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 1'b0, "R1 done at reset", done, 0);
        check(quotient == 3'd0, "R1 quotient at reset", quotient, 0);
        check(div_zero == 1'b0, "R1 div_zero at reset", div_zero, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 idle inputs ignored
        for (int k = 0; k < 6; k++) begin
            feed(k[0], 8'd200);
            check(done == 1'b0, "R8 idle input no done", done, 0);
        end
        check(quotient == 3'd0, "R8 idle input no result", quotient, 0);

        // table walk: R2 R3 R4 R5 R7 R10
        for (int v = 0; v < NVEC; v++) begin
            pulse_start();
            run_phases(VEC[v][71:8]);
            check_result(int'(VEC[v][7:4]), int'(VEC[v][3:0]), $sformatf("vec%0d R2 R3 R4", v));
        end

        // R6 result held after completion (last vector gave 2)
        repeat (4) @(negedge clk);
        check(quotient == 3'd2, "R6 quotient held", quotient, 2);

        // R8 wrong-phase and invalid inputs ignored, interleaved into vector 0
        pulse_start();
        feed(1'b0, 8'd16);
        feed(1'b1, 8'd255);
        in_valid = 1'b0; in_phase = 1'b0; in_data = 8'd255; @(negedge clk);
        feed(1'b0, 8'd16);
        feed(1'b0, 8'd16);
        feed(1'b1, 8'd99);
        feed(1'b0, 8'd16);
        feed(1'b0, 8'd250);
        feed(1'b1, 8'd40);
        feed(1'b1, 8'd40);
        in_valid = 1'b0; in_phase = 1'b1; in_data = 8'd255; @(negedge clk);
        feed(1'b1, 8'd40);
        check(done == 1'b0, "R8 no early done", done, 0);
        feed(1'b1, 8'd40);
        check_result(2, 0, "R8 interleaved");

        // R9 restart mid-phase with same-cycle divisor input
        pulse_start();
        feed(1'b0, 8'd16);
        feed(1'b0, 8'd16);
        start = 1'b1; in_valid = 1'b1; in_phase = 1'b0; in_data = 8'd255;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        run_phases({8'd16, 8'd16, 8'd16, 8'd16, 8'd40, 8'd40, 8'd40, 8'd40});
        check_result(2, 0, "R9 restart");

        // R9 restart during dividend phase clears the firing sum
        pulse_start();
        for (int t = 0; t < 4; t++) feed(1'b0, 8'd4);
        feed(1'b1, 8'd255);
        feed(1'b1, 8'd255);
        pulse_start();
        run_phases({8'd32, 8'd32, 8'd32, 8'd32, 8'd7, 8'd7, 8'd7, 8'd7});
        check_result(0, 0, "R9 restart in dividend phase");

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule